// File: doc/BRIEF.md
# Flash Page Update Sequencer

This block drives the programming of one page into an external serial flash. The same flash also serves execute-in-place code fetches, so those fetches must stop only for short stretches. The host first loads the page into a write buffer, which sits outside this block. It then releases the engine from its held state and sets a start bit. From that point the sequencer runs the whole update alone.

For each flash operation the sequencer asks a bus-ownership arbiter for the configuration and data paths. It sends a short series of commands to the flash controller and then gives the paths back. The write phase moves the buffered page. An optional busy-poll phase follows, in which status reads are spaced by a programmable timer. Between polls the buses are free again, so code fetches can continue. When the flash reports that it is no longer busy, the sequencer sets a done flag and can raise an interrupt.

Commands leave on a valid/ready channel. `cmd_valid` rises with `cmd_op` and both hold steady until the controller shows `cmd_ready` on a clock edge. The controller may hold `cmd_ready` low for as long as it needs. A single-cycle `resp_valid` pulse ends each command, and the sequencer takes no next command until it has seen that pulse. The arbiter handshake and the register port are plain level signals.

Top module: `page_update_seq`

## Requirements
- R1: Control register (address 0) bits 0, 1 and 2 are engine-hold, clock-off and memory-gate, and all three are 1 after reset. While any of them is 1, the engine requests no bus, starts no operation and clears the done flag. A start bit written in that state stays pending until all three are 0.
- R2: Control bit 3 is the start bit. The engine accepts it when enabled and idle, and the bit then reads back as 0. Status register (address 2) bit 0, busy, reads 1 from acceptance until completion.
- R3: The write phase raises `bus_req` and waits for `bus_gnt`. It then issues op 0 (write settings), op 1 (page transfer) and op 2 (restore settings), in that order, and drops `bus_req`.
- R4: `cmd_valid` stays high with `cmd_op` unchanged until `cmd_ready` is seen. A new command is never offered before `resp_valid` has ended the previous one.
- R5: With control bit 5 (poll enable) at 0, the engine completes straight after the write-phase release and requests no bus afterwards.
- R6: With poll enable at 1, each poll keeps `bus_req` low for N+1 cycles after the previous release, where N is the interval register (address 1). It then acquires the buses and issues op 3 (status settings), op 4 (status read) and op 2 (restore), and releases.
- R7: When bit 0 of the status byte returned by op 4 is 1, another timer-spaced poll follows. When it is 0, the page is complete.
- R8: Completion sets status bit 1 (done). Output `irq` is high while done is 1 and control bit 4 (interrupt enable) is 1.
- R9: A start bit written while busy is ignored: it does not read back as set and starts no second sequence.
- R10: An interval value of 0 behaves as 1, so `bus_req` stays low for exactly 2 cycles between polls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| cmd_valid | output | 1 | Command offered to flash controller |
| cmd_ready | input | 1 | Controller accepts command |
| cmd_op | output | 3 | Command code (0..4, see R3/R6) |
| resp_valid | input | 1 | Command finished pulse |
| resp_status | input | 8 | Status byte returned with op 4 |

## Verification
The hardest case to reach from the ports is a sequence that loops through more than one busy poll. To get there, the controller model has to hand back a list of status bytes, set beforehand, so that the write-in-progress bit stays 1 for several reads before it clears. A gap monitor on `bus_req` counts the low cycles before each re-acquire, and the bench compares the last gap with the programmed interval, including the interval value of zero. A start bit is written in the middle of the busy phase so that it lands while the engine is working.

// File: rtl/page_upd_pkg.sv
`timescale 1ns/1ps
package page_upd_pkg;
  typedef enum logic [2:0] {
    OP_CFG_WR  = 3'd0,
    OP_XFER    = 3'd1,
    OP_RESTORE = 3'd2,
    OP_CFG_RD  = 3'd3,
    OP_STAT_RD = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACQ, ST_CMD, ST_WAIT, ST_REL, ST_TMR
  } st_e;

  localparam int CTL_HOLD   = 0;
  localparam int CTL_CLKOFF = 1;
  localparam int CTL_GATE   = 2;
  localparam int CTL_GO     = 3;
  localparam int CTL_IRQEN  = 4;
  localparam int CTL_POLLEN = 5;
endpackage

// File: rtl/page_upd_regs.sv
`timescale 1ns/1ps
module page_upd_regs
  import page_upd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int IV_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              busy,
  input  logic              accept,
  input  logic              done_pulse,
  output logic              eng_en,
  output logic              go_pend,
  output logic              irq_en,
  output logic              poll_en,
  output logic [IV_W-1:0]   interval,
  output logic              done
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_IVAL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);

  logic hold_q, clkoff_q, gate_q;
  logic wr_ctrl, wr_ival;

  assign wr_ctrl = cfg_wr && (cfg_addr == A_CTRL);
  assign wr_ival = cfg_wr && (cfg_addr == A_IVAL);
  assign eng_en  = !(hold_q || clkoff_q || gate_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= 1'b1;
      clkoff_q <= 1'b1;
      gate_q   <= 1'b1;
      irq_en   <= 1'b0;
      poll_en  <= 1'b0;
      go_pend  <= 1'b0;
      interval <= '0;
      done     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        hold_q   <= cfg_wdata[CTL_HOLD];
        clkoff_q <= cfg_wdata[CTL_CLKOFF];
        gate_q   <= cfg_wdata[CTL_GATE];
        irq_en   <= cfg_wdata[CTL_IRQEN];
        poll_en  <= cfg_wdata[CTL_POLLEN];
      end
      if (wr_ival) interval <= cfg_wdata[IV_W-1:0];
      go_pend <= (go_pend && !accept) || (wr_ctrl && cfg_wdata[CTL_GO] && !busy);
      if (!eng_en || accept) done <= 1'b0;
      else if (done_pulse)   done <= 1'b1;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_CTRL: begin
        cfg_rdata[CTL_HOLD]   = hold_q;
        cfg_rdata[CTL_CLKOFF] = clkoff_q;
        cfg_rdata[CTL_GATE]   = gate_q;
        cfg_rdata[CTL_GO]     = go_pend;
        cfg_rdata[CTL_IRQEN]  = irq_en;
        cfg_rdata[CTL_POLLEN] = poll_en;
      end
      A_IVAL:  cfg_rdata[IV_W-1:0] = interval;
      A_STAT:  cfg_rdata[1:0] = {done, busy};
      default: cfg_rdata = '0;
    endcase
  end

  AST_GO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(wr_ctrl && cfg_wdata[CTL_GO])) |=> !go_pend); // R2
  AST_GO_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && cfg_wdata[CTL_GO] && busy && !go_pend) |=> !go_pend); // R9
endmodule

// File: rtl/page_upd_timer.sv
`timescale 1ns/1ps
module page_upd_timer #(
  parameter int IV_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IV_W-1:0] interval,
  output logic            expire
);
  logic [IV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= (interval == '0) ? IV_W'(1) : interval;
    else if (cnt != '0)     cnt <= cnt - IV_W'(1);
  end

  assign expire = (cnt == IV_W'(1));

  AST_TMR_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt != '0)); // R10
endmodule

// File: rtl/page_upd_ctrl.sv
`timescale 1ns/1ps
module page_upd_ctrl
  import page_upd_pkg::*;
#(
  parameter int STAT_W  = 8,
  parameter int WIP_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_en,
  input  logic              go_pend,
  input  logic              poll_en,
  input  logic              bus_gnt,
  input  logic              cmd_ready,
  input  logic              resp_valid,
  input  logic [STAT_W-1:0] resp_status,
  input  logic              tmr_expire,
  output logic              bus_req,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic              busy,
  output logic              accept,
  output logic              done_pulse,
  output logic              tmr_start
);
  localparam int STEPS = 3;
  localparam int SW    = $clog2(STEPS);

  st_e           st;
  logic [SW-1:0] step;
  logic          polling;
  logic          wip;

  assign busy      = (st != ST_IDLE);
  assign accept    = (st == ST_IDLE) && eng_en && go_pend;
  assign bus_req   = (st == ST_ACQ) || (st == ST_CMD) || (st == ST_WAIT);
  assign cmd_valid = (st == ST_CMD);
  assign tmr_start = (st == ST_REL) && (polling ? wip : poll_en);
  assign done_pulse = (st == ST_REL) && !tmr_start;

  always_comb begin
    case (step)
      SW'(0):  cmd_op = polling ? OP_CFG_RD  : OP_CFG_WR;
      SW'(1):  cmd_op = polling ? OP_STAT_RD : OP_XFER;
      default: cmd_op = OP_RESTORE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      step    <= '0;
      polling <= 1'b0;
      wip     <= 1'b0;
    end else if (!eng_en) begin
      st      <= ST_IDLE;
      step    <= '0;
      polling <= 1'b0;
      wip     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          st      <= ST_ACQ;
          step    <= '0;
          polling <= 1'b0;
          wip     <= 1'b0;
        end
        ST_ACQ:  if (bus_gnt) st <= ST_CMD;
        ST_CMD:  if (cmd_ready) st <= ST_WAIT;
        ST_WAIT: if (resp_valid) begin
          if (polling && step == SW'(1)) wip <= resp_status[WIP_BIT];
          if (step == SW'(STEPS-1)) st <= ST_REL;
          else begin
            step <= step + SW'(1);
            st   <= ST_CMD;
          end
        end
        ST_REL: begin
          step <= '0;
          if (tmr_start) begin
            st      <= ST_TMR;
            polling <= 1'b1;
          end else st <= ST_IDLE;
        end
        ST_TMR:  if (tmr_expire) st <= ST_ACQ;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && eng_en) |=> (cmd_valid && $stable(cmd_op))); // R4
  AST_CMD_WAITS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid); // R4
endmodule

// File: rtl/page_update_seq.sv
`timescale 1ns/1ps
module page_update_seq #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 2,
  parameter int IV_W    = 16,
  parameter int STAT_W  = 8,
  parameter int WIP_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              irq,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  input  logic              resp_valid,
  input  logic [STAT_W-1:0] resp_status
);
  logic eng_en, go_pend, irq_en, poll_en, done;
  logic busy, accept, done_pulse, tmr_start, tmr_expire;
  logic [IV_W-1:0] interval;

  page_upd_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IV_W(IV_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
    .accept(accept), .done_pulse(done_pulse), .eng_en(eng_en),
    .go_pend(go_pend), .irq_en(irq_en), .poll_en(poll_en),
    .interval(interval), .done(done)
  );

  page_upd_timer #(.IV_W(IV_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .interval(interval),
    .expire(tmr_expire)
  );

  page_upd_ctrl #(.STAT_W(STAT_W), .WIP_BIT(WIP_BIT)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .go_pend(go_pend),
    .poll_en(poll_en), .bus_gnt(bus_gnt), .cmd_ready(cmd_ready),
    .resp_valid(resp_valid), .resp_status(resp_status),
    .tmr_expire(tmr_expire), .bus_req(bus_req), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .busy(busy), .accept(accept),
    .done_pulse(done_pulse), .tmr_start(tmr_start)
  );

  assign irq = done && irq_en;

  AST_HELD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_en |=> !bus_req); // R1
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy)); // R8
endmodule

// File: tb/page_update_seq_tb_top.sv
`timescale 1ns/1ps
module page_update_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        irq, bus_req, cmd_valid;
  logic        bus_gnt, gnt_d, cmd_ready, resp_valid;
  logic [2:0]  cmd_op;
  logic [7:0]  resp_status;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  page_update_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .resp_valid(resp_valid),
    .resp_status(resp_status)
  );

  // arbiter model: grant two cycles after request, drop with request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin gnt_d <= 1'b0; bus_gnt <= 1'b0; end
    else begin gnt_d <= bus_req; bus_gnt <= bus_req && gnt_d; end
  end

  // controller model with back-pressure and delayed response
  logic [7:0] stat_vals [0:31];
  int         sidx = 0;
  logic [2:0] op_log [0:127];
  int         op_n = 0;
  logic       pend = 1'b0;
  int         dly = 0;
  logic [2:0] cur_op = '0;
  int         viol = 0;
  int         stalls = 0;
  logic       prev_stall = 1'b0;
  logic [2:0] prev_op = '0;
  int         low_cnt = 0;
  int         last_gap = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      cmd_ready <= 1'b0; resp_valid <= 1'b0; resp_status <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (prev_stall && !(cmd_valid && cmd_op == prev_op)) viol <= viol + 1;
      prev_stall <= cmd_valid && !cmd_ready;
      prev_op    <= cmd_op;
      if (cmd_valid && !cmd_ready) stalls <= stalls + 1;
      if (cmd_valid && cmd_ready) begin
        if (pend || !bus_gnt) viol <= viol + 1;
        op_log[op_n] <= cmd_op;
        op_n   <= op_n + 1;
        pend   <= 1'b1;
        dly    <= 3;
        cur_op <= cmd_op;
        cmd_ready <= 1'b0;
      end else if (pend) begin
        if (dly == 0) begin
          resp_valid <= 1'b1;
          pend <= 1'b0;
          if (cur_op == 3'd4) begin
            resp_status <= stat_vals[sidx];
            sidx <= sidx + 1;
          end else resp_status <= 8'h00;
        end else dly <= dly - 1;
      end else cmd_ready <= cmd_valid && !cmd_ready;
      if (!bus_req) low_cnt <= low_cnt + 1;
      else if (low_cnt > 0) begin last_gap <= low_cnt; low_cnt <= 0; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic wait_done(output bit ok);
    logic [15:0] s;
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      reg_rd(2'd2, s);
      if (s[1]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic chk_ops(input int start, input logic [2:0] exp[], input string req);
    chk(op_n - start == exp.size(), req, op_n - start, exp.size());
    for (int k = 0; k < exp.size() && start + k < op_n; k++)
      chk(op_log[start + k] == exp[k], req, int'(op_log[start + k]), int'(exp[k]));
  endtask

  task automatic t_reset();
    logic [15:0] d;
    reg_rd(2'd0, d); chk(d == 16'h0007, "R1 ctrl reset", d, 7);
    reg_rd(2'd2, d); chk(d == 16'h0000, "R2 status reset", d, 0);
    chk(irq == 1'b0 && bus_req == 1'b0, "R1 outputs reset", {irq, bus_req}, 0);
  endtask

  task automatic t_write_only();
    logic [15:0] d;
    bit ok;
    int st;
    reg_wr(2'd0, 16'h000F);
    repeat (10) @(negedge clk);
    chk(bus_req == 1'b0, "R1 held no req", bus_req, 0);
    reg_rd(2'd0, d); chk(d[3] == 1'b1, "R1 go pending while held", d[3], 1);
    reg_rd(2'd2, d); chk(d[0] == 1'b0, "R1 not busy while held", d[0], 0);
    st = op_n;
    reg_wr(2'd0, 16'h0000);
    @(negedge clk);
    reg_rd(2'd2, d); chk(d[0] == 1'b1, "R2 busy after accept", d[0], 1);
    reg_rd(2'd0, d); chk(d[3] == 1'b0, "R2 go self-clears", d[3], 0);
    wait_done(ok);
    chk(ok, "R5 done without polling", ok, 1);
    chk_ops(st, '{3'd0, 3'd1, 3'd2}, "R3 write order");
    reg_rd(2'd2, d); chk(d[0] == 1'b0, "R2 busy cleared", d[0], 0);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    repeat (20) @(negedge clk);
    chk(op_n == st + 3 && bus_req == 1'b0, "R5 no further ops", op_n - st, 3);
  endtask

  task automatic t_poll();
    logic [15:0] d;
    bit ok;
    int st;
    stat_vals[sidx] = 8'h03; stat_vals[sidx+1] = 8'h01; stat_vals[sidx+2] = 8'h02;
    reg_wr(2'd1, 16'd5);
    st = op_n;
    reg_wr(2'd0, 16'h0038);
    repeat (30) @(negedge clk);
    reg_wr(2'd0, 16'h0038);
    reg_rd(2'd0, d); chk(d[3] == 1'b0, "R9 go ignored while busy", d[3], 0);
    wait_done(ok);
    chk(ok, "R7 poll completes", ok, 1);
    chk_ops(st, '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd2, 3'd3, 3'd4, 3'd2,
                  3'd3, 3'd4, 3'd2}, "R7 poll repeats while wip");
    chk(last_gap == 6, "R6 poll gap", last_gap, 6);
    chk(irq == 1'b1, "R8 irq raised", irq, 1);
    repeat (40) @(negedge clk);
    chk(op_n == st + 12, "R9 no second sequence", op_n - st, 12);
  endtask

  task automatic t_zero_iv();
    bit ok;
    int st;
    stat_vals[sidx] = 8'h01; stat_vals[sidx+1] = 8'hFE;
    reg_wr(2'd1, 16'd0);
    st = op_n;
    reg_wr(2'd0, 16'h0038);
    wait_done(ok);
    chk(ok, "R10 done", ok, 1);
    chk(op_n - st == 9, "R10 op count", op_n - st, 9);
    chk(last_gap == 2, "R10 zero interval gap", last_gap, 2);
  endtask

  task automatic t_back_to_reset();
    logic [15:0] d;
    reg_wr(2'd0, 16'h0013);
    @(negedge clk);
    reg_rd(2'd2, d); chk(d[1] == 1'b0, "R1 done cleared on hold", d[1], 0);
    chk(irq == 1'b0, "R1 irq cleared on hold", irq, 0);
    chk(viol == 0, "R4 command handshake rules", viol, 0);
    chk(stalls > 0, "R4 back-pressure exercised", stalls, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_only();
    t_poll();
    t_zero_iv();
    t_back_to_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule